// File: doc/BRIEF.md
# Configuration Access Port (address latch and data window)

This block turns CPU I/O-space accesses into configuration-space requests. Software first writes a 32-bit target selector into an address latch, then reads or writes a four-byte data window. Each access to the window becomes one configuration read or write. The target is named by a bus number, a device/function number and a dword-aligned register offset, all taken from the latch. The byte lanes come from the access size and the low two bits of the CPU port address.

One target, bus 0 with device/function 0, is the host bridge itself, and the block answers it from a small built-in read-only header. Every other target is sent out on a request/response fabric port. The CPU access stalls until the response arrives, or until a fixed timeout expires, whichever comes first.

The CPU side uses a one-cycle `io_req` strobe. The block answers with a one-cycle `io_ack`. `io_claim` says whether the access was decoded. Read data is right-justified, and bits above the access width read as zero.

Top module: `cfg_access_port`

## Requirements
- R1: After reset, `io_ack` and `fab_req` are low and the address latch reads 0x00000000.
- R2: A claimed access that does not go to the fabric is acknowledged, with `io_claim` high, in the cycle after `io_req`. A 4-byte (size code 2) write to port 0xCF8 stores all 32 bits of the latch. A 4-byte read of port 0xCF8 returns them unchanged.
- R3: Some accesses are not claimed. These are: a 1- or 2-byte access (size codes 0, 1) to 0xCF8; any access to 0xCF9–0xCFB; a data-window access that runs past 0xCFF (2 bytes at 0xCFF, 4 bytes not at 0xCFC); size code 3; and any other port. Each is acknowledged in the next cycle with `io_claim` low and `io_rdata` all ones. It changes no state and issues no fabric request.
- R4: When latch bit 31 (enable) is 0, data-window accesses are claimed and acknowledged in the next cycle. A read returns ones in the access width (0xFF, 0xFFFF, 0xFFFFFFFF). A write is dropped. No fabric request is made.
- R5: A fabric request carries a 24-bit dword address {latch[23:16] bus, latch[15:8] device/function, latch[7:2] offset, 2'b00}, with latch bits 1:0 ignored. The byte enables are 1/3/F for 1/2/4 bytes, shifted left by port address bits 1:0. Write data is the access-width part of `io_wdata`, shifted to the same lanes.
- R6: Read data from the fabric is shifted right by 8×(port bits 1:0) and masked to the access width.
- R7: `fab_req` is a single-cycle pulse in the cycle after `io_req`. `io_ack` follows in the cycle after `fab_rsp` is sampled. While the block waits, further `io_req` strobes are ignored.
- R8: If `fab_rsp` is not sampled within 16 cycles of `fab_req`, the access completes 16 cycles after `fab_req`, with `io_claim` high. A read returns ones in its width, and a write completes silently.
- R9: With the enable bit set and latch bits 23:8 equal to zero, the built-in header is read locally at any width and lane. It holds: vendor 0x8086 at offsets 0–1, device 0x1237 at 2–3, revision 0x02 at 8, sub-class 0x00 at 0x0A, base class 0x06 at 0x0B, header type 0x00 at 0x0E, and zero elsewhere. Writes to it are dropped and no fabric request is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | One-cycle CPU access strobe |
| io_addr | input | 16 | CPU I/O port address |
| io_size | input | 2 | Size code: 0=1 byte, 1=2 bytes, 2=4 bytes, 3=reserved |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_wdata | input | 32 | Right-justified write data |
| io_ack | output | 1 | One-cycle access completion |
| io_claim | output | 1 | Access was decoded (valid with io_ack) |
| io_rdata | output | 32 | Right-justified read data (valid with io_ack) |
| fab_req | output | 1 | One-cycle fabric request strobe |
| fab_addr | output | 24 | Bus, device/function, dword offset |
| fab_be | output | 4 | Byte enables within the dword |
| fab_wr | output | 1 | Fabric request is a write |
| fab_wdata | output | 32 | Lane-aligned write data |
| fab_rsp | input | 1 | Fabric response strobe |
| fab_rdata | input | 32 | Full-dword read data, valid with fab_rsp |

## Verification
A behavioural model in the bench predicts the acknowledge, claim and read data and every fabric request field, and checks them against the outputs each cycle. Address-latch traffic is tried with full-width and narrow accesses. This separates a claimed latch write from an ignored one. The data window is driven at every lane and size, both with the enable bit clear and with it set, which separates the local header, the disabled path and the fabric path. Fabric responses come after zero, several and fifteen cycles, and never. Those cases pin the stall length and the timeout boundary, and a strobe issued during a stall shows that it is ignored.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } io_size_e;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_LATCH = 2'd1,
    K_WINDOW = 2'd2
  } acc_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } fsm_e;

  function automatic logic [31:0] width_mask(io_size_e sz);
    case (sz)
      SZ_BYTE: width_mask = 32'h0000_00FF;
      SZ_HALF: width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cap_decode.sv
module cap_decode
  import cap_pkg::*;
#(
  parameter int unsigned IO_AW = 16,
  parameter logic [IO_AW-1:0] LATCH_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] WINDOW_PORT = 16'h0CFC
) (
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  output acc_kind_e        kind,
  output logic [1:0]       lane,
  output logic [3:0]       be,
  output logic [31:0]      wmask
);

  io_size_e   sz;
  logic       at_latch;
  logic       in_window;
  logic       fits;
  logic [3:0] base_be;

  assign sz        = io_size_e'(io_size);
  assign lane      = io_addr[1:0];
  assign at_latch  = (io_addr == LATCH_PORT);
  assign in_window = (io_addr[IO_AW-1:2] == WINDOW_PORT[IO_AW-1:2]);
  assign wmask     = width_mask(sz);
  assign be        = base_be << lane;

  always_comb begin
    case (sz)
      SZ_BYTE: begin base_be = 4'b0001; fits = 1'b1;            end
      SZ_HALF: begin base_be = 4'b0011; fits = (lane != 2'd3);  end
      SZ_WORD: begin base_be = 4'b1111; fits = (lane == 2'd0);  end
      default: begin base_be = 4'b0000; fits = 1'b0;            end
    endcase
  end

  always_comb begin
    if (at_latch && (sz == SZ_WORD))  kind = K_LATCH;
    else if (in_window && fits)       kind = K_WINDOW;
    else                              kind = K_NONE;
  end

endmodule

// File: rtl/cap_hdr_rom.sv
module cap_hdr_rom #(
  parameter logic [15:0] VENDOR_ID  = 16'h8086,
  parameter logic [15:0] DEVICE_ID  = 16'h1237,
  parameter logic [7:0]  REVISION   = 8'h02,
  parameter logic [7:0]  SUB_CLASS  = 8'h00,
  parameter logic [7:0]  BASE_CLASS = 8'h06,
  parameter logic [7:0]  HDR_TYPE   = 8'h00
) (
  input  logic [5:0]  dw_idx,
  output logic [31:0] dword
);

  always_comb begin
    case (dw_idx)
      6'd0:    dword = {DEVICE_ID, VENDOR_ID};
      6'd2:    dword = {BASE_CLASS, SUB_CLASS, 8'h00, REVISION};
      6'd3:    dword = {8'h00, HDR_TYPE, 16'h0000};
      default: dword = 32'h0000_0000;
    endcase
  end

endmodule

// File: rtl/cap_wait_timer.sv
module cap_wait_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic expired
);

  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign expired = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
  import cap_pkg::*;
#(
  parameter int unsigned IO_AW = 16,
  parameter logic [IO_AW-1:0] LATCH_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] WINDOW_PORT = 16'h0CFC,
  parameter int unsigned TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  input  logic             io_wr,
  input  logic [31:0]      io_wdata,
  output logic             io_ack,
  output logic             io_claim,
  output logic [31:0]      io_rdata,
  output logic             fab_req,
  output logic [23:0]      fab_addr,
  output logic [3:0]       fab_be,
  output logic             fab_wr,
  output logic [31:0]      fab_wdata,
  input  logic             fab_rsp,
  input  logic [31:0]      fab_rdata
);

  acc_kind_e   kind;
  logic [1:0]  lane;
  logic [3:0]  be;
  logic [31:0] wmask;

  logic [31:0] latch_q;
  fsm_e        state_q, state_d;
  logic        ack_q, ack_d;
  logic        claim_q, claim_d;
  logic [31:0] rdata_q, rdata_d;
  logic        freq_q, freq_d;
  logic [23:0] faddr_q;
  logic [3:0]  fbe_q;
  logic        fwr_q;
  logic [31:0] fwdata_q;
  logic [1:0]  lane_q;
  logic [31:0] mask_q;

  logic        latch_we;
  logic        launch;
  logic        busy;
  logic        tmr_step;
  logic        tmr_exp;
  logic        local_tgt;
  logic [31:0] hdr_dw;

  cap_decode #(
    .IO_AW(IO_AW), .LATCH_PORT(LATCH_PORT), .WINDOW_PORT(WINDOW_PORT)
  ) u_dec (
    .io_addr(io_addr), .io_size(io_size), .kind(kind),
    .lane(lane), .be(be), .wmask(wmask)
  );

  cap_hdr_rom u_hdr (
    .dw_idx(latch_q[7:2]), .dword(hdr_dw)
  );

  cap_wait_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(launch), .step(tmr_step), .expired(tmr_exp)
  );

  assign busy      = (state_q == ST_WAIT);
  assign local_tgt = (latch_q[23:8] == 16'h0000);
  assign tmr_step  = busy && !fab_rsp && !tmr_exp;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    ack_d    = 1'b0;
    claim_d  = 1'b0;
    rdata_d  = 32'h0;
    freq_d   = 1'b0;
    latch_we = 1'b0;
    launch   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (io_req) begin
          case (kind)
            K_LATCH: begin
              ack_d   = 1'b1;
              claim_d = 1'b1;
              if (io_wr) latch_we = 1'b1;
              else       rdata_d  = latch_q;
            end
            K_WINDOW: begin
              if (!latch_q[31]) begin
                ack_d   = 1'b1;
                claim_d = 1'b1;
                if (!io_wr) rdata_d = wmask;
              end else if (local_tgt) begin
                ack_d   = 1'b1;
                claim_d = 1'b1;
                if (!io_wr) rdata_d = (hdr_dw >> {lane, 3'b000}) & wmask;
              end else begin
                launch  = 1'b1;
                freq_d  = 1'b1;
                state_d = ST_WAIT;
              end
            end
            default: begin
              ack_d   = 1'b1;
              rdata_d = 32'hFFFF_FFFF;
            end
          endcase
        end
      end
      default: begin
        if (fab_rsp) begin
          ack_d   = 1'b1;
          claim_d = 1'b1;
          if (!fwr_q) rdata_d = (fab_rdata >> {lane_q, 3'b000}) & mask_q;
          state_d = ST_IDLE;
        end else if (tmr_exp) begin
          ack_d   = 1'b1;
          claim_d = 1'b1;
          if (!fwr_q) rdata_d = mask_q;
          state_d = ST_IDLE;
        end
      end
    endcase
  end

  // Control and response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
      claim_q <= 1'b0;
      rdata_q <= 32'h0;
      freq_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      claim_q <= claim_d;
      rdata_q <= rdata_d;
      freq_q  <= freq_d;
    end
  end

  // Address latch with write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= 32'h0;
    else if (latch_we) latch_q <= io_wdata;
  end

  // Fabric request capture, enabled on launch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faddr_q  <= 24'h0;
      fbe_q    <= 4'h0;
      fwr_q    <= 1'b0;
      fwdata_q <= 32'h0;
      lane_q   <= 2'd0;
      mask_q   <= 32'h0;
    end else if (launch) begin
      faddr_q  <= {latch_q[23:2], 2'b00};
      fbe_q    <= be;
      fwr_q    <= io_wr;
      fwdata_q <= (io_wdata & wmask) << {lane, 3'b000};
      lane_q   <= lane;
      mask_q   <= wmask;
    end
  end

  assign io_ack    = ack_q;
  assign io_claim  = claim_q;
  assign io_rdata  = rdata_q;
  assign fab_req   = freq_q;
  assign fab_addr  = faddr_q;
  assign fab_be    = fbe_q;
  assign fab_wr    = fwr_q;
  assign fab_wdata = fwdata_q;

endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int unsigned IO_AW = 16,
  parameter logic [IO_AW-1:0] WINDOW_PORT = 16'h0CFC,
  parameter int unsigned TIMEOUT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_req,
  input logic [IO_AW-1:0] io_addr,
  input logic             io_ack,
  input logic             io_claim,
  input logic [31:0]      io_rdata,
  input logic             fab_req,
  input logic             fab_rsp,
  input logic             busy,
  input logic             latch_en
);

  localparam int unsigned CW = $clog2(TIMEOUT) + 2;

  logic [CW-1:0] wait_cnt;
  logic          win_hit;

  assign win_hit = (io_addr[IO_AW-1:2] == WINDOW_PORT[IO_AW-1:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wait_cnt <= '0;
    else if (busy) wait_cnt <= wait_cnt + 1'b1;
    else           wait_cnt <= '0;
  end

  p_unclaimed_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_ack && !io_claim) |-> (io_rdata == 32'hFFFF_FFFF));

  p_disabled_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !busy && win_hit && !latch_en) |=> !fab_req);

  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fab_req |=> !fab_req);

  p_req_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fab_req |-> ($past(io_req) && !io_ack));

  p_rsp_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fab_rsp) |=> (io_ack && io_claim));

  p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (wait_cnt < CW'(TIMEOUT)));

endmodule

bind cfg_access_port cap_checker #(
  .IO_AW(IO_AW), .WINDOW_PORT(WINDOW_PORT), .TIMEOUT(TIMEOUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_addr(io_addr),
  .io_ack(io_ack), .io_claim(io_claim), .io_rdata(io_rdata),
  .fab_req(fab_req), .fab_rsp(fab_rsp), .busy(busy), .latch_en(latch_q[31])
);

// File: tb/tb_cfg_access_port.sv
module tb_cfg_access_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic [1:0]  io_size = 2'd0;
  logic        io_wr = 1'b0;
  logic [31:0] io_wdata = 32'h0;
  logic        io_ack, io_claim;
  logic [31:0] io_rdata;
  logic        fab_req, fab_wr;
  logic [23:0] fab_addr;
  logic [3:0]  fab_be;
  logic [31:0] fab_wdata;
  logic        fab_rsp = 1'b0;
  logic [31:0] fab_rdata = 32'h0;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #5 clk = ~clk;

  cfg_access_port dut (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_addr(io_addr),
    .io_size(io_size), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_ack(io_ack), .io_claim(io_claim), .io_rdata(io_rdata),
    .fab_req(fab_req), .fab_addr(fab_addr), .fab_be(fab_be),
    .fab_wr(fab_wr), .fab_wdata(fab_wdata),
    .fab_rsp(fab_rsp), .fab_rdata(fab_rdata)
  );

  function automatic logic [31:0] mask_of(int n);
    if (n >= 4) return 32'hFFFF_FFFF;
    return (32'h1 << (8 * n)) - 32'h1;
  endfunction

  function automatic int bytes_of(logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] hdr_byte(int off);
    case (off)
      0: return 8'h86;
      1: return 8'h80;
      2: return 8'h37;
      3: return 8'h12;
      8: return 8'h02;
      11: return 8'h06;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] pattern(logic [23:0] a);
    return {8'hC3 ^ a[7:0], a[23:16], a[15:8], 8'h5A};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_latch;
  bit          m_busy;
  int          m_wait, m_lane, m_n;
  bit          m_wr;
  logic        e_ack, e_claim, e_freq, e_fwr;
  logic [31:0] e_rdata, e_fwdata;
  logic [23:0] e_faddr;
  logic [3:0]  e_fbe;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_latch = 0; m_busy = 0; m_wait = 0; m_lane = 0; m_n = 0; m_wr = 0;
      e_ack = 0; e_claim = 0; e_freq = 0; e_fwr = 0;
      e_rdata = 0; e_fwdata = 0; e_faddr = 0; e_fbe = 0;
    end else begin
      e_ack = 0; e_claim = 0; e_rdata = 0; e_freq = 0;
      if (m_busy) begin
        if (fab_rsp) begin
          e_ack = 1; e_claim = 1; m_busy = 0;
          if (!m_wr) e_rdata = (fab_rdata >> (8 * m_lane)) & mask_of(m_n);
        end else begin
          m_wait++;
          if (m_wait == 16) begin
            e_ack = 1; e_claim = 1; m_busy = 0;
            if (!m_wr) e_rdata = mask_of(m_n);
          end
        end
      end else if (io_req) begin
        int a, n, ln, off;
        logic [31:0] v;
        a = int'(io_addr);
        n = bytes_of(io_size);
        if (a == 'hCF8 && n == 4) begin
          e_ack = 1; e_claim = 1;
          if (io_wr) m_latch = io_wdata;
          else       e_rdata = m_latch;
        end else if (a >= 'hCFC && a <= 'hCFF && n != 0 && (a - 'hCFC) + n <= 4) begin
          ln = a - 'hCFC;
          if (!m_latch[31]) begin
            e_ack = 1; e_claim = 1;
            if (!io_wr) e_rdata = mask_of(n);
          end else if (m_latch[23:8] == 16'h0) begin
            e_ack = 1; e_claim = 1;
            if (!io_wr) begin
              off = int'(m_latch[7:2]) * 4 + ln;
              v = 0;
              for (int i = 0; i < n; i++) v = v | (32'(hdr_byte(off + i)) << (8 * i));
              e_rdata = v;
            end
          end else begin
            e_freq = 1;
            e_faddr = {m_latch[23:2], 2'b00};
            e_fbe = 4'(((1 << n) - 1) << ln);
            e_fwr = io_wr;
            e_fwdata = (io_wdata & mask_of(n)) << (8 * ln);
            m_busy = 1; m_wait = 0; m_lane = ln; m_n = n; m_wr = io_wr;
          end
        end else begin
          e_ack = 1; e_rdata = 32'hFFFF_FFFF;
        end
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (io_ack !== e_ack || io_claim !== e_claim || fab_req !== e_freq ||
          (e_ack && io_rdata !== e_rdata) ||
          (e_freq && (fab_addr !== e_faddr || fab_be !== e_fbe ||
                      fab_wr !== e_fwr || fab_wdata !== e_fwdata))) begin
        errors++;
        $display("FAIL %s model: actual ack=%b claim=%b rd=%h freq=%b fa=%h be=%h fw=%b wd=%h expected ack=%b claim=%b rd=%h freq=%b fa=%h be=%h fw=%b wd=%h",
                 cur_req, io_ack, io_claim, io_rdata, fab_req, fab_addr, fab_be, fab_wr, fab_wdata,
                 e_ack, e_claim, e_rdata, e_freq, e_faddr, e_fbe, e_fwr, e_fwdata);
      end
    end
  end

  // Fabric responder
  int          rsp_delay = 0;
  int          rcnt = 0;
  bit          armed = 0;
  logic [23:0] last_addr = 0;
  logic [3:0]  last_be = 0;
  logic [31:0] last_wdata = 0;

  always @(negedge clk) begin
    fab_rsp = 1'b0;
    if (fab_req) begin
      armed = 1; rcnt = rsp_delay;
      last_addr = fab_addr; last_be = fab_be; last_wdata = fab_wdata;
    end
    if (armed && rsp_delay >= 0) begin
      if (rcnt == 0) begin
        fab_rsp = 1'b1; fab_rdata = pattern(last_addr); armed = 0;
      end else rcnt--;
    end
  end

  task automatic do_io(input logic [15:0] a, input logic [1:0] sz, input logic wr,
                       input logic [31:0] wd, output logic [31:0] rd,
                       output logic cl, output int lat);
    @(negedge clk);
    io_addr = a; io_size = sz; io_wr = wr; io_wdata = wd; io_req = 1'b1;
    @(negedge clk);
    io_req = 1'b0;
    lat = 1;
    while (!io_ack) begin
      @(negedge clk);
      lat++;
    end
    rd = io_rdata;
    cl = io_claim;
  endtask

  task automatic set_latch(logic [31:0] v);
    logic [31:0] rd; logic cl; int lat;
    do_io(16'hCF8, 2'd2, 1'b1, v, rd, cl, lat);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd; logic cl; int lat;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R1";
    chk("R1 ack after reset", 32'(io_ack), 32'h0);
    chk("R1 fab_req after reset", 32'(fab_req), 32'h0);
    do_io(16'hCF8, 2'd2, 1'b0, 0, rd, cl, lat);
    chk("R1 latch reset value", rd, 32'h0);

    cur_req = "R2";
    do_io(16'hCF8, 2'd2, 1'b1, 32'h7ACE_0F0F, rd, cl, lat);
    chk("R2 write latency", 32'(lat), 32'd1);
    do_io(16'hCF8, 2'd2, 1'b0, 0, rd, cl, lat);
    chk("R2 readback", rd, 32'h7ACE_0F0F);
    chk("R2 claimed", 32'(cl), 32'h1);

    cur_req = "R3";
    do_io(16'hCF8, 2'd0, 1'b0, 0, rd, cl, lat);
    chk("R3 byte read of latch not claimed", 32'(cl), 32'h0);
    chk("R3 byte read of latch data", rd, 32'hFFFF_FFFF);
    do_io(16'hCF8, 2'd1, 1'b1, 32'h0000_1111, rd, cl, lat);
    do_io(16'hCF8, 2'd2, 1'b0, 0, rd, cl, lat);
    chk("R3 narrow write left latch", rd, 32'h7ACE_0F0F);
    do_io(16'hCF9, 2'd2, 1'b1, 32'h0, rd, cl, lat);
    chk("R3 0xCF9 not claimed", 32'(cl), 32'h0);
    set_latch(32'h8003_0000);
    do_io(16'hCFF, 2'd1, 1'b0, 0, rd, cl, lat);
    chk("R3 half at 0xCFF not claimed", 32'(cl), 32'h0);
    do_io(16'hCFE, 2'd2, 1'b0, 0, rd, cl, lat);
    chk("R3 word at 0xCFE not claimed", 32'(cl), 32'h0);
    do_io(16'hCFC, 2'd3, 1'b0, 0, rd, cl, lat);
    chk("R3 reserved size not claimed", 32'(cl), 32'h0);
    do_io(16'h0080, 2'd0, 1'b0, 0, rd, cl, lat);
    chk("R3 foreign port not claimed", 32'(cl), 32'h0);

    cur_req = "R4";
    set_latch(32'h0001_0800);
    do_io(16'hCFD, 2'd0, 1'b0, 0, rd, cl, lat);
    chk("R4 disabled byte read", rd, 32'h0000_00FF);
    do_io(16'hCFE, 2'd1, 1'b0, 0, rd, cl, lat);
    chk("R4 disabled half read", rd, 32'h0000_FFFF);
    do_io(16'hCFC, 2'd2, 1'b0, 0, rd, cl, lat);
    chk("R4 disabled word read", rd, 32'hFFFF_FFFF);
    do_io(16'hCFC, 2'd2, 1'b1, 32'h1234_5678, rd, cl, lat);
    chk("R4 disabled write latency", 32'(lat), 32'd1);

    cur_req = "R9";
    set_latch(32'h8000_0000);
    do_io(16'hCFC, 2'd2, 1'b0, 0, rd, cl, lat);
    chk("R9 vendor/device", rd, 32'h1237_8086);
    do_io(16'hCFC, 2'd0, 1'b0, 0, rd, cl, lat);
    chk("R9 vendor low byte", rd, 32'h0000_0086);
    do_io(16'hCFE, 2'd1, 1'b0, 0, rd, cl, lat);
    chk("R9 device half", rd, 32'h0000_1237);
    do_io(16'hCFC, 2'd2, 1'b1, 32'hDEAD_BEEF, rd, cl, lat);
    do_io(16'hCFC, 2'd2, 1'b0, 0, rd, cl, lat);
    chk("R9 write dropped", rd, 32'h1237_8086);
    set_latch(32'h8000_0008);
    do_io(16'hCFC, 2'd2, 1'b0, 0, rd, cl, lat);
    chk("R9 class/revision", rd, 32'h0600_0002);
    do_io(16'hCFF, 2'd0, 1'b0, 0, rd, cl, lat);
    chk("R9 base class byte", rd, 32'h0000_0006);
    set_latch(32'h8000_000D);
    do_io(16'hCFE, 2'd1, 1'b0, 0, rd, cl, lat);
    chk("R9 header type, low latch bits ignored", rd, 32'h0000_0000);

    cur_req = "R5";
    rsp_delay = 2;
    set_latch(32'h8002_1846);
    do_io(16'hCFE, 2'd0, 1'b1, 32'h1234_56AB, rd, cl, lat);
    chk("R5 fabric address", 32'(last_addr), 32'h0002_1844);
    chk("R5 byte enables", 32'(last_be), 32'h0000_0004);
    chk("R5 lane data", last_wdata, 32'h00AB_0000);
    set_latch(32'h8000_0100);
    do_io(16'hCFC, 2'd2, 1'b0, 0, rd, cl, lat);
    chk("R5 devfn 1 goes to fabric", 32'(last_addr), 32'h0000_0100);

    cur_req = "R6";
    set_latch(32'h8002_1844);
    do_io(16'hCFD, 2'd1, 1'b0, 0, rd, cl, lat);
    chk("R6 half lane 1 extract", rd, (pattern(24'h021844) >> 8) & 32'hFFFF);
    do_io(16'hCFF, 2'd0, 1'b0, 0, rd, cl, lat);
    chk("R6 byte lane 3 extract", rd, pattern(24'h021844) >> 24);

    cur_req = "R7";
    rsp_delay = 0;
    do_io(16'hCFC, 2'd2, 1'b0, 0, rd, cl, lat);
    chk("R7 latency with immediate response", 32'(lat), 32'd2);
    rsp_delay = 15;
    do_io(16'hCFC, 2'd2, 1'b0, 0, rd, cl, lat);
    chk("R7 latency with last-chance response", 32'(lat), 32'd17);
    chk("R7 late response data", rd, pattern(24'h021844));
    rsp_delay = 5;
    @(negedge clk);
    io_addr = 16'hCFC; io_size = 2'd2; io_wr = 1'b0; io_req = 1'b1;
    @(negedge clk);
    io_addr = 16'hCF8; io_wr = 1'b1; io_wdata = 32'h0;
    @(negedge clk);
    io_req = 1'b0;
    while (!io_ack) @(negedge clk);
    do_io(16'hCF8, 2'd2, 1'b0, 0, rd, cl, lat);
    chk("R7 strobe during wait ignored", rd, 32'h8002_1844);

    cur_req = "R8";
    rsp_delay = -1;
    do_io(16'hCFE, 2'd1, 1'b0, 0, rd, cl, lat);
    chk("R8 timeout latency", 32'(lat), 32'd17);
    chk("R8 timeout read ones", rd, 32'h0000_FFFF);
    chk("R8 timeout claimed", 32'(cl), 32'h1);
    do_io(16'hCFC, 2'd2, 1'b1, 32'h5555_AAAA, rd, cl, lat);
    chk("R8 timeout write data", rd, 32'h0);
    rsp_delay = 1;
    do_io(16'hCFC, 2'd2, 1'b0, 0, rd, cl, lat);
    chk("R8 next access after timeout", rd, pattern(24'h021844));

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule